// File: doc/BRIEF.md
# Bank Conflict Serialization Unit

This unit stands between the lanes of a vector core and a scratchpad split into several single-ported banks. An instruction presents one request per lane. Each request has a byte address, a write word, a byte-enable mask and an active bit. One store flag covers every lane, and a start strobe asks for the instruction to be taken. For every lane the unit works out which bank the word lives in and where it sits inside that bank. Bank selection interleaves words cyclically across the banks. The unit then hands the memory side one conflict-free group of lanes per cycle.

When no two active lanes compete for a bank, the instruction goes out in the cycle it is accepted and the unit stays ready, so instructions can follow one another every cycle. When lanes do collide, the unit takes a private copy of the instruction and enters its busy state. It then emits one pass per cycle until every active lane has been served, and becomes ready again after the final pass. Lanes that carry exactly the same address share a single pass as a broadcast; they are not treated as a conflict.

The controller has two states. `ST_IDLE` is the ready state and `ST_SERIAL` is the busy state. The transition *accept-conflict* (`ST_IDLE`→`ST_SERIAL`) is taken when an accepted instruction leaves lanes unserved after its first pass. The transition *drain-done* (`ST_SERIAL`→`ST_IDLE`) is taken in the cycle that issues the final pass. Each state otherwise holds.

Top module: `spm_conflict_serializer`

## Requirements
- R1: After reset, `rdy` is 1 and `pass_vld` is 0.
- R2: For each lane, `pass_bank` equals address bits [BYTE_W+BANK_W-1:BYTE_W] and `pass_row` equals the address bits above them. With the default parameters these are bits [3:2] and bits [7:4].
- R3: An instruction is accepted only in a cycle where `go` and `rdy` are both 1. If its active lanes fall in distinct banks, the same cycle shows `pass_vld`=1, `pass_lanes` equal to the active bits and `pass_last`=1, and `rdy` is still 1 in the next cycle.
- R4: An accepted instruction that needs n>1 passes shows pass 1 in the acceptance cycle and passes 2..n on the following consecutive cycles. `rdy` is 0 from the cycle after acceptance through the cycle of pass n, `pass_last` is 1 only on pass n, and `rdy` is 1 again in the cycle after pass n.
- R5: In every pass, each bank serves the lowest-numbered active lane that maps to it and has not yet been served.
- R6: Any unserved active lane whose address is identical to that of a lane chosen in a pass is issued in that same pass. No two lanes issued together share a bank while having different rows.
- R7: A lane whose active bit is 0 never appears in `pass_lanes` and does not cause extra passes.
- R8: While `rdy` is 0, `go` and every lane input are ignored. The passes that remain come from the values captured when the instruction was accepted.
- R9: Every pass of an instruction carries that instruction's store flag, and each issued lane carries its captured write word and byte mask.
- R10: In a cycle where `rdy` is 1 and `go` is 0, `pass_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Request to accept an instruction |
| wr_op | input | 1 | Shared store flag (1 = scatter, 0 = gather) |
| lane_on | input | LANES | Per-lane active bit |
| lane_addr | input | LANES x ADDR_W | Per-lane byte address |
| lane_wdata | input | LANES x 8·BYTES | Per-lane write word |
| lane_be | input | LANES x BYTES | Per-lane byte enables |
| rdy | output | 1 | High in the ready state |
| pass_vld | output | 1 | A pass is issued this cycle |
| pass_last | output | 1 | This is the final pass of the instruction |
| pass_wr | output | 1 | Store flag of the instruction being issued |
| pass_lanes | output | LANES | Lanes issued in this pass |
| pass_bank | output | LANES x BANK_W | Bank index per lane |
| pass_row | output | LANES x ROW_W | Offset inside the bank per lane |
| pass_wdata | output | LANES x 8·BYTES | Write word per lane |
| pass_be | output | LANES x BYTES | Byte enables per lane |

## Verification
The hardest case to reach is a single bank that holds a chain of lanes where duplicates of one address are interleaved with different addresses. In that case the choice of lowest lane and the broadcast merge act together within one pass. The directed stimulus builds this case explicitly: in one bank, lanes 0 and 3 share an address and lane 2 has another, while a separate bank takes lane 1. The expected pass masks are therefore fixed in advance. A second case holds `go` high and changes every lane input while the unit is draining a four-way conflict. The remaining passes must follow the captured copy and ignore the live inputs.

// File: rtl/spm_ser_pkg.sv
package spm_ser_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SERIAL = 1'b1
    } ser_state_t;

endpackage

// File: rtl/spm_addr_split.sv
module spm_addr_split #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 2,
    parameter int BANK_W = 2
) (
    input  logic [ADDR_W-1:0]               addr,
    output logic [BANK_W-1:0]               bank,
    output logic [ADDR_W-BYTE_W-BANK_W-1:0] row
);
    localparam int ROW_W = ADDR_W - BYTE_W - BANK_W;

    // word index = addr >> BYTE_W; bank = word mod banks; row = word / banks
    always_comb begin
        bank = addr[BYTE_W +: BANK_W];
        row  = addr[ADDR_W-1 -: ROW_W];
    end
endmodule

// File: rtl/spm_pass_pick.sv
module spm_pass_pick #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8,
    parameter int BANK_W = 2
) (
    input  logic [LANES-1:0][ADDR_W-1:0] addr,
    input  logic [LANES-1:0][BANK_W-1:0] bank,
    input  logic [LANES-1:0]             pending,
    output logic [LANES-1:0]             issue,
    output logic [LANES-1:0]             left_over
);
    logic [LANES-1:0] head;

    // head: lowest pending lane of its bank
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            head[l] = pending[l];
            for (int j = 0; j < l; j++) begin
                if (pending[j] && (bank[j] == bank[l])) begin
                    head[l] = 1'b0;
                end
            end
        end
    end

    // a pending lane goes out if some head holds the very same address
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            issue[l] = 1'b0;
            for (int k = 0; k < LANES; k++) begin
                if (pending[l] && head[k] && (addr[k] == addr[l])) begin
                    issue[l] = 1'b1;
                end
            end
        end
        left_over = pending & ~issue;
    end
endmodule

// File: rtl/spm_req_hold.sv
module spm_req_hold #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          wr_in,
    input  logic [LANES-1:0]              on_in,
    input  logic [LANES-1:0][ADDR_W-1:0]  addr_in,
    input  logic [LANES-1:0][8*BYTES-1:0] data_in,
    input  logic [LANES-1:0][BYTES-1:0]   be_in,
    output logic                          wr_q,
    output logic [LANES-1:0]              on_q,
    output logic [LANES-1:0][ADDR_W-1:0]  addr_q,
    output logic [LANES-1:0][8*BYTES-1:0] data_q,
    output logic [LANES-1:0][BYTES-1:0]   be_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            on_q <= '0;
        end else if (load) begin
            wr_q <= wr_in;
            on_q <= on_in;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (load) begin
                    addr_q[g] <= addr_in[g];
                    data_q[g] <= data_in[g];
                    be_q[g]   <= be_in[g];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/spm_conflict_serializer.sv
module spm_conflict_serializer
    import spm_ser_pkg::*;
#(
    parameter int LANES = 4,
    parameter int BANKS = 4,
    parameter int BYTES = 4,
    parameter int DEPTH = 16,
    localparam int BYTE_W = $clog2(BYTES),
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(DEPTH),
    localparam int ADDR_W = ROW_W + BANK_W + BYTE_W,
    localparam int DATA_W = 8 * BYTES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  logic                          wr_op,
    input  logic [LANES-1:0]              lane_on,
    input  logic [LANES-1:0][ADDR_W-1:0]  lane_addr,
    input  logic [LANES-1:0][DATA_W-1:0]  lane_wdata,
    input  logic [LANES-1:0][BYTES-1:0]   lane_be,
    output logic                          rdy,
    output logic                          pass_vld,
    output logic                          pass_last,
    output logic                          pass_wr,
    output logic [LANES-1:0]              pass_lanes,
    output logic [LANES-1:0][BANK_W-1:0]  pass_bank,
    output logic [LANES-1:0][ROW_W-1:0]   pass_row,
    output logic [LANES-1:0][DATA_W-1:0]  pass_wdata,
    output logic [LANES-1:0][BYTES-1:0]   pass_be
);
    ser_state_t state_q, state_d;

    logic                         accept;
    logic                         hold_wr;
    logic [LANES-1:0]             hold_on;
    logic [LANES-1:0][ADDR_W-1:0] hold_addr;
    logic [LANES-1:0][DATA_W-1:0] hold_data;
    logic [LANES-1:0][BYTES-1:0]  hold_be;

    logic                         src_wr;
    logic [LANES-1:0]             src_on;
    logic [LANES-1:0][ADDR_W-1:0] src_addr;
    logic [LANES-1:0][DATA_W-1:0] src_data;
    logic [LANES-1:0][BYTES-1:0]  src_be;
    logic [LANES-1:0][BANK_W-1:0] src_bank;
    logic [LANES-1:0][ROW_W-1:0]  src_row;

    logic [LANES-1:0] served_q;
    logic [LANES-1:0] pending;
    logic [LANES-1:0] issue;
    logic [LANES-1:0] left_over;
    logic             in_idle;

    assign in_idle = (state_q == ST_IDLE);
    assign accept  = in_idle && go;

    spm_req_hold #(
        .LANES (LANES),
        .ADDR_W(ADDR_W),
        .BYTES (BYTES)
    ) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .wr_in  (wr_op),
        .on_in  (lane_on),
        .addr_in(lane_addr),
        .data_in(lane_wdata),
        .be_in  (lane_be),
        .wr_q   (hold_wr),
        .on_q   (hold_on),
        .addr_q (hold_addr),
        .data_q (hold_data),
        .be_q   (hold_be)
    );

    // live inputs in the accepting cycle, captured copy while draining
    always_comb begin
        if (in_idle) begin
            src_wr   = wr_op;
            src_on   = lane_on;
            src_addr = lane_addr;
            src_data = lane_wdata;
            src_be   = lane_be;
            pending  = lane_on;
        end else begin
            src_wr   = hold_wr;
            src_on   = hold_on;
            src_addr = hold_addr;
            src_data = hold_data;
            src_be   = hold_be;
            pending  = hold_on & ~served_q;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_map
            spm_addr_split #(
                .ADDR_W(ADDR_W),
                .BYTE_W(BYTE_W),
                .BANK_W(BANK_W)
            ) i_split (
                .addr(src_addr[g]),
                .bank(src_bank[g]),
                .row (src_row[g])
            );
        end
    endgenerate

    spm_pass_pick #(
        .LANES (LANES),
        .ADDR_W(ADDR_W),
        .BANK_W(BANK_W)
    ) i_pick (
        .addr     (src_addr),
        .bank     (src_bank),
        .pending  (pending),
        .issue    (issue),
        .left_over(left_over)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go && (left_over != '0)) state_d = ST_SERIAL;
            ST_SERIAL: if (left_over == '0)         state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and served tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            served_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                served_q <= issue;
            end else if (!in_idle) begin
                served_q <= served_q | issue;
            end
        end
    end

    // outputs
    always_comb begin
        rdy        = 1'b0;
        pass_vld   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rdy      = 1'b1;
                pass_vld = go;
            end
            ST_SERIAL: begin
                rdy      = 1'b0;
                pass_vld = 1'b1;
            end
            default: begin
                rdy      = 1'b0;
                pass_vld = 1'b0;
            end
        endcase
        pass_last  = pass_vld && (left_over == '0);
        pass_wr    = src_wr;
        pass_lanes = pass_vld ? issue : '0;
        pass_bank  = src_bank;
        pass_row   = src_row;
        pass_wdata = src_data;
        pass_be    = src_be;
    end
endmodule

// File: rtl/spm_conflict_serializer_chk.sv
module spm_conflict_serializer_chk #(
    parameter int LANES  = 4,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         go,
    input logic                         wr_op,
    input logic [LANES-1:0]             lane_on,
    input logic                         rdy,
    input logic                         pass_vld,
    input logic                         pass_last,
    input logic                         pass_wr,
    input logic [LANES-1:0]             pass_lanes,
    input logic [LANES-1:0][BANK_W-1:0] pass_bank,
    input logic [LANES-1:0][ROW_W-1:0]  pass_row
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !go) |-> !pass_vld); // R10

    AST_FAST_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_vld && pass_last) |=> rdy); // R3

    AST_DRAIN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_vld && !pass_last) |=> (!rdy && pass_vld)); // R4

    AST_OFF_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && pass_vld) |-> ((pass_lanes & ~lane_on) == '0)); // R7

    AST_STORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy) |-> (pass_wr == $past(pass_wr))); // R9

    AST_ACCEPT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && go) |-> (pass_wr == wr_op)); // R9

    genvar i, j;
    generate
        for (i = 0; i < LANES; i++) begin : g_i
            for (j = i + 1; j < LANES; j++) begin : g_j
                AST_NO_BANK_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
                    (pass_lanes[i] && pass_lanes[j] && (pass_bank[i] == pass_bank[j]))
                    |-> (pass_row[i] == pass_row[j])); // R6
            end
        end
    endgenerate
endmodule

bind spm_conflict_serializer spm_conflict_serializer_chk #(
    .LANES (LANES),
    .BANK_W(BANK_W),
    .ROW_W (ROW_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .wr_op     (wr_op),
    .lane_on   (lane_on),
    .rdy       (rdy),
    .pass_vld  (pass_vld),
    .pass_last (pass_last),
    .pass_wr   (pass_wr),
    .pass_lanes(pass_lanes),
    .pass_bank (pass_bank),
    .pass_row  (pass_row)
);

// File: tb/test_spm_conflict_serializer.sv
module test_spm_conflict_serializer;
    localparam int L = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic wr_op = 1'b0;
    logic [L-1:0]       lane_on = '0;
    logic [L-1:0][7:0]  lane_addr = '0;
    logic [L-1:0][31:0] lane_wdata = '0;
    logic [L-1:0][3:0]  lane_be = '0;
    logic rdy, pass_vld, pass_last, pass_wr;
    logic [L-1:0]       pass_lanes;
    logic [L-1:0][1:0]  pass_bank;
    logic [L-1:0][3:0]  pass_row;
    logic [L-1:0][31:0] pass_wdata;
    logic [L-1:0][3:0]  pass_be;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    spm_conflict_serializer i_spm_conflict_serializer (
        .clk(clk), .rst_n(rst_n), .go(go), .wr_op(wr_op),
        .lane_on(lane_on), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .lane_be(lane_be),
        .rdy(rdy), .pass_vld(pass_vld), .pass_last(pass_last),
        .pass_wr(pass_wr), .pass_lanes(pass_lanes), .pass_bank(pass_bank),
        .pass_row(pass_row), .pass_wdata(pass_wdata), .pass_be(pass_be)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, let combinational outputs settle
    task automatic drive(input logic g, input logic w, input logic [3:0] on,
                         input logic [7:0] a0, input logic [7:0] a1,
                         input logic [7:0] a2, input logic [7:0] a3);
        @(negedge clk);
        go = g; wr_op = w; lane_on = on;
        lane_addr[0] = a0; lane_addr[1] = a1; lane_addr[2] = a2; lane_addr[3] = a3;
        for (int i = 0; i < L; i++) begin
            lane_wdata[i] = {a0, a1, 8'(i), 8'h5A} ^ {24'h0, 8'(cyc)};
            lane_be[i]    = 4'(i + 1) ^ on;
        end
        #2;
    endtask

    task automatic pass_is(input string req, input logic r, input logic [3:0] m,
                           input logic lst);
        chk(req, "rdy", 64'(rdy), 64'(r));
        chk(req, "pass_vld", 64'(pass_vld), 64'd1);
        chk(req, "pass_lanes", 64'(pass_lanes), 64'(m));
        chk(req, "pass_last", 64'(pass_last), 64'(lst));
    endtask

    task automatic t_reset;
        chk("R1", "rdy after reset", 64'(rdy), 64'd1);
        chk("R1", "pass_vld after reset", 64'(pass_vld), 64'd0);
    endtask

    task automatic t_idle;
        drive(1'b0, 1'b0, 4'hF, 8'h00, 8'h04, 8'h08, 8'h0C);
        chk("R10", "pass_vld without go", 64'(pass_vld), 64'd0);
    endtask

    // R2/R3: distinct banks, back to back
    task automatic t_fast;
        drive(1'b1, 1'b1, 4'hF, 8'h34, 8'hF8, 8'h0C, 8'h50);
        pass_is("R3", 1'b1, 4'hF, 1'b1);
        for (int i = 0; i < L; i++) begin
            chk("R2", "bank", 64'(pass_bank[i]), 64'((lane_addr[i] >> 2) & 8'h3));
            chk("R2", "row", 64'(pass_row[i]), 64'(lane_addr[i] >> 4));
            chk("R9", "wdata", 64'(pass_wdata[i]), 64'(lane_wdata[i]));
        end
        chk("R9", "store", 64'(pass_wr), 64'd1);
        drive(1'b1, 1'b0, 4'h3, 8'hA0, 8'hA4, 8'h00, 8'h00);
        pass_is("R3", 1'b1, 4'h3, 1'b1);
        chk("R9", "gather flag", 64'(pass_wr), 64'd0);
        drive(1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R3", "ready after fast pair", 64'(rdy), 64'd1);
    endtask

    // R4/R8/R9: four-way conflict in bank 0, inputs scrambled while busy
    task automatic t_fourway;
        logic [3:0][31:0] wd;
        logic [3:0][3:0]  be;
        drive(1'b1, 1'b1, 4'hF, 8'h00, 8'h10, 8'h20, 8'h30);
        wd = lane_wdata; be = lane_be;
        pass_is("R4", 1'b1, 4'b0001, 1'b0);
        for (int p = 1; p < 4; p++) begin
            drive(1'b1, 1'b0, 4'hF, 8'h04, 8'h08, 8'h0C, 8'h00);
            pass_is("R4", 1'b0, 4'(1 << p), 1'(p == 3));
            chk("R8", "captured row", 64'(pass_row[p]), 64'(p));
            chk("R8", "captured bank", 64'(pass_bank[p]), 64'd0);
            chk("R9", "store each pass", 64'(pass_wr), 64'd1);
            chk("R9", "captured wdata", 64'(pass_wdata[p]), 64'(wd[p]));
            chk("R9", "captured be", 64'(pass_be[p]), 64'(be[p]));
        end
        drive(1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R4", "ready after drain", 64'(rdy), 64'd1);
        chk("R10", "quiet after drain", 64'(pass_vld), 64'd0);
    endtask

    // R5: lowest lane first within one bank
    task automatic t_order;
        drive(1'b1, 1'b0, 4'h7, 8'h24, 8'h04, 8'h44, 8'h00);
        pass_is("R5", 1'b1, 4'b0001, 1'b0);
        drive(1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00);
        pass_is("R5", 1'b0, 4'b0010, 1'b0);
        drive(1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00);
        pass_is("R5", 1'b0, 4'b0100, 1'b1);
        drive(1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R5", "ready after order test", 64'(rdy), 64'd1);
    endtask

    // R6: broadcast merge of lanes 0 and 3, lane 2 waits
    task automatic t_bcast;
        drive(1'b1, 1'b0, 4'hF, 8'h00, 8'h14, 8'h10, 8'h00);
        pass_is("R6", 1'b1, 4'b1011, 1'b0);
        drive(1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00);
        pass_is("R6", 1'b0, 4'b0100, 1'b1);
        drive(1'b1, 1'b0, 4'hF, 8'h40, 8'h40, 8'h40, 8'h40);
        pass_is("R6", 1'b1, 4'hF, 1'b1);
    endtask

    // R7: inactive lanes collide but are ignored
    task automatic t_inactive;
        drive(1'b1, 1'b0, 4'b0101, 8'h00, 8'h10, 8'h04, 8'h14);
        pass_is("R7", 1'b1, 4'b0101, 1'b1);
        drive(1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R7", "no extra pass", 64'(pass_vld), 64'd0);
        chk("R7", "stays ready", 64'(rdy), 64'd1);
    endtask

    initial begin
        #1;
        t_reset;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_idle;
        t_fast;
        t_fourway;
        t_order;
        t_bcast;
        t_inactive;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule